// File: doc/BRIEF.md
# Periodic Thermistor Temperature Converter

This block turns the voltage of a biased thermistor node into a panel temperature reading. On a fixed, slow refresh period it asks an external 10-bit successive-approximation ADC for one conversion. When the ADC answers, the block maps the sample onto a signed byte in whole degrees Celsius and stores it in a readout register. The output therefore holds the latest reading, stays constant between refreshes, and reads 0x00 until the first conversion has finished.

The node voltage falls as the panel warms. It sits near 1.575 V at 0 °C and drops about 15.8 mV for each degree. The ADC spans 2.25 V, so one code is about 2.2 mV. The conversion therefore subtracts the sample from the code expected at 0 °C and scales the difference by a fixed-point reciprocal. The result is clamped to the supported span of -10 °C to +85 °C.

A hot flag is updated together with every new reading. It sets at a trip temperature and clears only once the reading has fallen to a lower release temperature, so a reading that hovers near one limit does not toggle the flag. The refresh period is a parameter in clock ticks. Its default of 600,000,000 ticks gives 60 s at 10 MHz.

Top module: `thermistor_temp_monitor`

## Requirements
- R1: After synchronous reset, `temp_code` is 0x00, `hot` is 0 and `adc_start` is 0.
- R2: `adc_start` is a single-cycle pulse. It is high during the cycle after the PERIOD_TICKS-th rising edge following reset release, and then every PERIOD_TICKS cycles after that.
- R3: A refresh point reached while a conversion is still outstanding issues no pulse. A conversion is outstanding from its `adc_start` pulse up to and including the cycle whose `adc_done` answers it. The next pulse then comes at the following refresh point.
- R4: An `adc_done` with no conversion outstanding is ignored: `temp_code` and `hot` keep their values.
- R5: When an outstanding conversion receives `adc_done`, `temp_code` takes the new value after that same rising edge. With the defaults, the value is T = floor(((717 - sample) * 9114 + 32768) / 65536). Examples: sample 717 gives 0x00, 537 gives 0x19 (25), and 724 gives 0xFF (-1).
- R6: A computed T below -10 is reported as 0xF6 (-10). For example, sample 1023 gives 0xF6.
- R7: A computed T above 85 is reported as 0x55 (85). For example, sample 0 gives 0x55.
- R8: `hot` becomes 1 with a new reading that is 50 or above.
- R9: `hot` becomes 0 with a new reading that is 45 or below. A new reading from 46 to 49 leaves `hot` unchanged.
- R10: `temp_code` and `hot` change only on the rising edge that accepts an `adc_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_start | output | 1 | One-cycle request for an ADC conversion |
| adc_done | input | 1 | ADC result valid, one cycle |
| adc_sample | input | 10 | ADC result code |
| temp_code | output | 8 | Temperature, two's complement, 1 °C per LSB |
| hot | output | 1 | Over-temperature flag with hysteresis |

## Verification
All outputs are registered, so each result is due at the first falling edge after the rising edge that causes it. The first request appears PERIOD_TICKS edges after reset release, and later requests follow every PERIOD_TICKS edges. A new reading and its hot flag both appear one edge after the accepted `adc_done`. The bench's reference model advances on each rising edge from the same inputs, and every output is compared with it at every falling edge. Directed checks add hand-computed values for the temperature codes, the clamps, both hysteresis limits, a skipped refresh and a stray done.

// File: rtl/tmon_pkg.sv
package tmon_pkg;

  // Default geometry and calibration of the converter
  localparam int TMON_ADC_W      = 10;
  localparam int TMON_TEMP_W     = 8;
  localparam int TMON_ZERO_CODE  = 717;   // sample expected at 0 degC
  localparam int TMON_RECIP      = 9114;  // (2.25 V / 1024 / 15.8 mV) * 2^16
  localparam int TMON_RECIP_FRAC = 16;
  localparam int TMON_MIN_C      = -10;
  localparam int TMON_MAX_C      = 85;
  localparam int TMON_HOT_C      = 50;
  localparam int TMON_COOL_C     = 45;

  typedef enum logic {
    THERM_NORMAL = 1'b0,
    THERM_HOT    = 1'b1
  } therm_state_e;

endpackage

// File: rtl/tmon_refresh_timer.sv
module tmon_refresh_timer #(
  parameter int PERIOD_TICKS = 600_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic done_in,
  output logic start_out,
  output logic accept_out
);

  localparam int CNT_W = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_TICKS - 1);

  logic [CNT_W-1:0] tick_cnt;
  logic             wrap;
  logic             pending;
  logic             start_q;

  assign wrap       = (tick_cnt == LAST);
  assign accept_out = done_in && pending;
  assign start_out  = start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt <= '0;
    end else if (wrap) begin
      tick_cnt <= '0;
    end else begin
      tick_cnt <= tick_cnt + 1'b1;
    end
  end

  // A refresh point is dropped while a request is still open
  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      pending <= 1'b0;
    end else begin
      start_q <= wrap && !pending;
      if (wrap && !pending) begin
        pending <= 1'b1;
      end else if (accept_out) begin
        pending <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tmon_code_map.sv
module tmon_code_map #(
  parameter int ADC_W      = 10,
  parameter int TEMP_W     = 8,
  parameter int ZERO_CODE  = 717,
  parameter int RECIP      = 9114,
  parameter int RECIP_FRAC = 16,
  parameter int MIN_C      = -10,
  parameter int MAX_C      = 85
) (
  input  logic [ADC_W-1:0]  sample,
  output logic [TEMP_W-1:0] temp
);

  localparam int DIFF_W  = ADC_W + 2;
  localparam int RECIP_W = $clog2(RECIP + 1) + 1;
  localparam int PROD_W  = DIFF_W + RECIP_W + 1;
  localparam int HALF    = 1 << (RECIP_FRAC - 1);

  localparam logic signed [PROD_W-1:0] K_RECIP = PROD_W'(RECIP);
  localparam logic signed [PROD_W-1:0] K_HALF  = PROD_W'(HALF);
  localparam logic signed [PROD_W-1:0] K_LO    = PROD_W'(MIN_C);
  localparam logic signed [PROD_W-1:0] K_HI    = PROD_W'(MAX_C);
  localparam logic signed [DIFF_W-1:0] K_ZERO  = DIFF_W'(ZERO_CODE);

  logic signed [DIFF_W-1:0] diff;
  logic signed [PROD_W-1:0] diff_ext;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] rounded;
  logic signed [PROD_W-1:0] scaled;

  always_comb begin
    diff     = K_ZERO - $signed({2'b00, sample});
    diff_ext = {{(PROD_W - DIFF_W){diff[DIFF_W-1]}}, diff};
    prod     = diff_ext * K_RECIP;
    rounded  = prod + K_HALF;
    scaled   = rounded >>> RECIP_FRAC;
    if (scaled < K_LO) begin
      temp = K_LO[TEMP_W-1:0];
    end else if (scaled > K_HI) begin
      temp = K_HI[TEMP_W-1:0];
    end else begin
      temp = scaled[TEMP_W-1:0];
    end
  end

endmodule

// File: rtl/tmon_hot_hyst.sv
module tmon_hot_hyst
  import tmon_pkg::*;
#(
  parameter int TEMP_W = 8,
  parameter int HOT_C  = 50,
  parameter int COOL_C = 45
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [TEMP_W-1:0] temp,
  output logic              hot
);

  localparam logic signed [TEMP_W-1:0] K_TRIP    = TEMP_W'(HOT_C);
  localparam logic signed [TEMP_W-1:0] K_RELEASE = TEMP_W'(COOL_C);

  therm_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= THERM_NORMAL;
    end else if (load) begin
      if ($signed(temp) >= K_TRIP) begin
        state <= THERM_HOT;
      end else if ($signed(temp) <= K_RELEASE) begin
        state <= THERM_NORMAL;
      end
    end
  end

  assign hot = (state == THERM_HOT);

endmodule

// File: rtl/thermistor_temp_monitor.sv
module thermistor_temp_monitor
  import tmon_pkg::*;
#(
  parameter int ADC_W        = TMON_ADC_W,
  parameter int TEMP_W       = TMON_TEMP_W,
  parameter int PERIOD_TICKS = 600_000_000,
  parameter int ZERO_CODE    = TMON_ZERO_CODE,
  parameter int RECIP        = TMON_RECIP,
  parameter int RECIP_FRAC   = TMON_RECIP_FRAC,
  parameter int MIN_C        = TMON_MIN_C,
  parameter int MAX_C        = TMON_MAX_C,
  parameter int HOT_C        = TMON_HOT_C,
  parameter int COOL_C       = TMON_COOL_C
) (
  input  logic              clk,
  input  logic              rst,
  output logic              adc_start,
  input  logic              adc_done,
  input  logic [ADC_W-1:0]  adc_sample,
  output logic [TEMP_W-1:0] temp_code,
  output logic              hot
);

  logic              accept;
  logic [TEMP_W-1:0] mapped;
  logic [TEMP_W-1:0] temp_q;

  tmon_refresh_timer #(
    .PERIOD_TICKS(PERIOD_TICKS)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .done_in   (adc_done),
    .start_out (adc_start),
    .accept_out(accept)
  );

  tmon_code_map #(
    .ADC_W     (ADC_W),
    .TEMP_W    (TEMP_W),
    .ZERO_CODE (ZERO_CODE),
    .RECIP     (RECIP),
    .RECIP_FRAC(RECIP_FRAC),
    .MIN_C     (MIN_C),
    .MAX_C     (MAX_C)
  ) u_map (
    .sample(adc_sample),
    .temp  (mapped)
  );

  // Readout register, replaced whole on each accepted result
  always_ff @(posedge clk) begin
    if (rst) begin
      temp_q <= '0;
    end else if (accept) begin
      temp_q <= mapped;
    end
  end

  assign temp_code = temp_q;

  tmon_hot_hyst #(
    .TEMP_W(TEMP_W),
    .HOT_C (HOT_C),
    .COOL_C(COOL_C)
  ) u_hyst (
    .clk (clk),
    .rst (rst),
    .load(accept),
    .temp(mapped),
    .hot (hot)
  );

endmodule

// File: rtl/thermistor_temp_monitor_chk.sv
module thermistor_temp_monitor_chk #(
  parameter int TEMP_W = 8,
  parameter int MIN_C  = -10,
  parameter int MAX_C  = 85,
  parameter int HOT_C  = 50,
  parameter int COOL_C = 45
) (
  input logic              clk,
  input logic              rst,
  input logic              adc_start,
  input logic              adc_done,
  input logic [TEMP_W-1:0] temp_code,
  input logic              hot
);

  logic busy;
  logic accepted;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
    end else begin
      busy <= (busy || adc_start) && !adc_done;
    end
  end

  assign accepted = adc_done && (busy || adc_start);

  assert_start_single_R2: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);

  assert_no_start_while_busy_R3: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> !busy);

  assert_hold_between_results_R10: assert property (@(posedge clk) disable iff (rst)
    !accepted |=> ($stable(temp_code) && $stable(hot)));

  assert_reading_in_span_R6: assert property (@(posedge clk) disable iff (rst)
    (int'($signed(temp_code)) >= MIN_C) && (int'($signed(temp_code)) <= MAX_C));

  assert_hot_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(hot) |-> int'($signed(temp_code)) >= HOT_C);

  assert_hot_fall_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(hot) |-> int'($signed(temp_code)) <= COOL_C);

endmodule

bind thermistor_temp_monitor thermistor_temp_monitor_chk #(
  .TEMP_W(TEMP_W),
  .MIN_C (MIN_C),
  .MAX_C (MAX_C),
  .HOT_C (HOT_C),
  .COOL_C(COOL_C)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .adc_start(adc_start),
  .adc_done (adc_done),
  .temp_code(temp_code),
  .hot      (hot)
);

// File: tb/thermistor_temp_monitor_tb.sv
module thermistor_temp_monitor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PERIOD     = 40;
  localparam int LAT        = 5;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       adc_start;
  logic       adc_done = 1'b0;
  logic [9:0] adc_sample = '0;
  logic [7:0] temp_code;
  logic       hot;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference model state
  int m_cnt, m_temp;
  bit m_pend, m_start, m_hot, m_acc, m_wrap;

  always #(CLK_PERIOD / 2) clk = ~clk;

  thermistor_temp_monitor #(.PERIOD_TICKS(PERIOD)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .adc_start (adc_start),
    .adc_done  (adc_done),
    .adc_sample(adc_sample),
    .temp_code (temp_code),
    .hot       (hot)
  );

  function automatic int ref_temp(input int s);
    int p, t;
    p = (717 - s) * 9114 + 32768;
    t = p >>> 16;
    if (t < -10) t = -10;
    if (t > 85) t = 85;
    return t;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model of the requirements, stepped on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_pend = 0; m_start = 0; m_temp = 0; m_hot = 0;
    end else begin
      m_acc  = adc_done && m_pend;
      m_wrap = (m_cnt == PERIOD - 1);
      m_start = m_wrap && !m_pend;
      if (m_acc) begin
        m_temp = ref_temp(int'(adc_sample));
        if (m_temp >= 50) m_hot = 1;
        else if (m_temp <= 45) m_hot = 0;
      end
      if (m_start) m_pend = 1;
      else if (m_acc) m_pend = 0;
      m_cnt = m_wrap ? 0 : m_cnt + 1;
    end
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(adc_start == m_start, "R2/R3 start", int'(adc_start), int'(m_start));
      check(int'($signed(temp_code)) == m_temp, "R5/R10 temp", int'($signed(temp_code)), m_temp);
      check(hot == m_hot, "R8/R9 hot", int'(hot), int'(m_hot));
    end
  end

  task automatic wait_start(output int waited);
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!adc_start && waited < 4 * PERIOD);
  endtask

  task automatic answer(input int s);
    repeat (LAT) @(negedge clk);
    adc_done   = 1'b1;
    adc_sample = 10'(s);
    @(negedge clk);
    adc_done = 1'b0;
  endtask

  task automatic convert(input int s, input int exp_t, input bit exp_h, input string req);
    int w;
    wait_start(w);
    answer(s);
    check(int'($signed(temp_code)) == exp_t, req, int'($signed(temp_code)), exp_t);
    check(hot == exp_h, req, int'(hot), int'(exp_h));
  endtask

  initial begin
    int w, seen;
    repeat (3) @(negedge clk);
    // R1: reset values
    check(temp_code == 8'h00, "R1 temp", int'(temp_code), 0);
    check(hot == 1'b0, "R1 hot", int'(hot), 0);
    check(adc_start == 1'b0, "R1 start", int'(adc_start), 0);
    rst = 1'b0;

    // R2: first request after PERIOD edges, one cycle wide
    wait_start(w);
    check(w == PERIOD, "R2 first start", w, PERIOD);
    @(negedge clk);
    check(adc_start == 1'b0, "R2 width", int'(adc_start), 0);
    adc_done = 1'b1; adc_sample = 10'd537;
    @(negedge clk);
    adc_done = 1'b0;
    check(temp_code == 8'h19, "R5 25C", int'(temp_code), 8'h19);
    wait_start(w);
    check(w == PERIOD - 2, "R2 interval", w, PERIOD - 2);
    answer(717);
    check(temp_code == 8'h00, "R5 0C", int'(temp_code), 0);

    convert(357, 50, 1'b1, "R8 trip at 50");
    convert(376, 47, 1'b1, "R9 hold at 47");
    // R4: stray done with sample that would map to 85
    repeat (3) @(negedge clk);
    adc_done = 1'b1; adc_sample = 10'd0;
    @(negedge clk);
    adc_done = 1'b0;
    @(negedge clk);
    check(int'($signed(temp_code)) == 47, "R4 stray temp", int'($signed(temp_code)), 47);
    check(hot == 1'b1, "R4 stray hot", int'(hot), 1);
    convert(390, 45, 1'b0, "R9 release at 45");
    convert(376, 47, 1'b0, "R9 hold low at 47");
    convert(0, 85, 1'b1, "R7 clamp high");
    convert(1023, -10, 1'b0, "R6 clamp low");
    convert(724, -1, 1'b0, "R5 minus one");

    // R3: withhold the answer across two refresh points
    wait_start(w);
    seen = 0;
    repeat (2 * PERIOD + 3) begin
      @(negedge clk);
      if (adc_start) seen++;
    end
    check(seen == 0, "R3 skipped refresh", seen, 0);
    answer(537);
    check(temp_code == 8'h19, "R3 late answer", int'(temp_code), 8'h19);
    convert(717, 0, 1'b0, "R5 after skip");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", WATCHDOG, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule